// File: doc/BRIEF.md
# Eight-Slot Serial Audio Receiver

This block takes a serial audio link made of four lines: a bit clock, a word select, a data line and a frame marker. All four are brought into a faster system clock through two-flop synchronisers, and edges of the bit clock are detected in the system domain. The bit clock must run at no more than one third of the system clock rate. Each rising bit-clock edge then acts as a one-cycle enable for the rest of the logic. Data is sampled on rising bit-clock edges. Every half-period of word select carries one 32-bit slot, sent MSB first. The MSB arrives one bit after the word-select change, and the slot is closed by the next change.

The block has two modes. In stereo mode it is a plain two-channel receiver. Word select low gives channel 0 and high gives channel 1, and the frame marker has no effect. In eight-slot mode the word select toggles four times as fast, so one sampling period holds four left/right pairs. The frame marker rises together with the word-select change that opens the first pair. The channel index is two times the pair number plus the word-select side. A marker rise anywhere else is a framing error, and the block discards slots until the next well-placed marker. The block also produces a transmit bit-clock enable. In stereo mode it pulses on every received bit-clock edge. In eight-slot mode it pulses on every fourth edge.

Top module: `octa_rx`

## Requirements
- R1: During and directly after reset, `smp_valid`, `frame_err` and `tx_bclk_en` are 0, and `smp_data` and `smp_chan` are 0.
- R2: In stereo mode (`quad_en`=0), a slot is the 32 bits captured on rising bit-clock edges from the bit after a word-select change up to and including the bit of the next change, MSB first. The slot is output unmodified with `smp_chan` 0 if word select was low during it and 1 if high.
- R3: The slot closed by the first word-select change after reset is incomplete and is never output.
- R4: In stereo mode the frame marker is ignored. The output words and channels are the same for any marker pattern, and `frame_err` stays 0.
- R5: In eight-slot mode (`quad_en`=1), a marker rise sampled together with a word-select high-to-low change sets the pair number to 0 and aligns the receiver. `smp_chan` is 2×pair+side, where side 0 is word select low. No slot is output until the first such alignment, and this includes the slot closed on the aligning edge.
- R6: Once aligned, the pair number advances on each word-select high-to-low change and wraps from 3 to 0 without further markers.
- R7: In eight-slot mode, a marker rise not sampled together with a high-to-low word-select change gives a one-cycle `frame_err` pulse. It also drops the slot closed on that edge and all slots after it, until the next aligning marker rise.
- R8: In stereo mode, `tx_bclk_en` pulses for one system cycle once per rising bit-clock edge.
- R9: In eight-slot mode, `tx_bclk_en` pulses on the 1st, 5th, 9th, … rising bit-clock edges counted from reset, so there is exactly one pulse every four edges.
- R10: `smp_valid` is a single-cycle pulse that follows a detected rising bit-clock edge. There is at most one pulse per bit-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least three times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_en | input | 1 | 0: stereo mode, 1: eight-slot mode; held static outside reset |
| bclk_in | input | 1 | Asynchronous serial bit clock |
| ws_in | input | 1 | Asynchronous word select |
| mark_in | input | 1 | Asynchronous frame marker |
| sd_in | input | 1 | Asynchronous serial data |
| smp_data | output | 32 | Received slot, MSB first on the line |
| smp_chan | output | 3 | Channel index of `smp_data` |
| smp_valid | output | 1 | One-cycle strobe for `smp_data`/`smp_chan` |
| frame_err | output | 1 | One-cycle framing-error strobe |
| tx_bclk_en | output | 1 | Transmit bit-clock enable |

## Verification
The case of interest is a slot that closes on the same bit-clock edge as a marker rise. When that rise comes with a low-to-high word-select change, the same edge both ends a slot and raises a framing error. The bench provokes this with a one-bit marker pulse placed exactly on such a change, and a second pulse in mid-slot for contrast. A bench model built from the requirements predicts the slot list and the error count. The result is judged correct if the colliding slot never appears, exactly one error pulse is seen for each misplaced rise, and output resumes with channel 0 after the next aligning marker.

// File: rtl/octa_rx_pkg.sv
package octa_rx_pkg;

    typedef enum logic {
        MODE_STEREO = 1'b0,
        MODE_QUAD   = 1'b1
    } rx_mode_e;

    // Synchronised serial lines, sampled together at a bit-clock rise.
    typedef struct packed {
        logic ws;
        logic mk;
        logic sd;
    } line_t;

    // Channel index from the pair number and the word-select side.
    function automatic int unsigned slot_index(input int unsigned pair, input logic side);
        return pair * 2 + int'(side);
    endfunction

endpackage

// File: rtl/octa_rx_sync.sv
module octa_rx_sync
    import octa_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk_raw,
    input  logic  ws_raw,
    input  logic  mk_raw,
    input  logic  sd_raw,
    output line_t lines,
    output logic  bclk_rise
);
    localparam int NLINES = 4;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              bclk_prev;

    assign raw = {bclk_raw, ws_raw, mk_raw, sd_raw};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= {q[STAGES-2:0], raw[i]};
        end
        assign synced[i] = q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= synced[3];
    end

    assign bclk_rise = synced[3] & ~bclk_prev;
    assign lines     = '{ws: synced[2], mk: synced[1], sd: synced[0]};

endmodule

// File: rtl/octa_rx_shift.sv
module octa_rx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sd,
    output logic [W-1:0] word
);
    logic [W-2:0] sh;

    assign word = {sh, sd};

    always_ff @(posedge clk) begin
        if (rst)           sh <= '0;
        else if (shift_en) sh <= word[W-2:0];
    end

endmodule

// File: rtl/octa_rx_frame.sv
module octa_rx_frame
    import octa_rx_pkg::*;
#(
    parameter int PAIRS = 4,
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int CH_W   = PAIR_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            quad,
    input  logic            step,
    input  line_t           ln,
    output logic            slot_keep,
    output logic [CH_W-1:0] slot_chan,
    output logic            err
);
    logic              ws_q;
    logic              mk_q;
    logic              primed;
    logic              locked;
    logic [PAIR_W-1:0] pair;

    logic ws_chg;
    logic new_pair;
    logic mk_rise;
    logic good_mark;

    assign ws_chg    = step & (ln.ws != ws_q);
    assign new_pair  = ws_chg & ws_q & ~ln.ws;
    assign mk_rise   = step & quad & ln.mk & ~mk_q;
    assign good_mark = mk_rise & new_pair;
    assign err       = mk_rise & ~new_pair;

    assign slot_keep = ws_chg & primed & (~quad | (locked & ~err));
    assign slot_chan = quad ? CH_W'(slot_index(int'(pair), ws_q)) : CH_W'(ws_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q   <= 1'b0;
            mk_q   <= 1'b0;
            primed <= 1'b0;
            locked <= 1'b0;
            pair   <= '0;
        end else begin
            if (step) begin
                ws_q <= ln.ws;
                mk_q <= ln.mk;
            end
            if (ws_chg) primed <= 1'b1;
            if (err) begin
                locked <= 1'b0;
            end else if (good_mark) begin
                locked <= 1'b1;
                pair   <= '0;
            end else if (new_pair) begin
                pair <= (pair == PAIR_W'(PAIRS - 1)) ? '0 : pair + PAIR_W'(1);
            end
        end
    end

endmodule

// File: rtl/octa_rx_txdiv.sv
module octa_rx_txdiv #(
    parameter int DIV = 4,
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic quad,
    input  logic step,
    output logic tx_en
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            tx_en <= 1'b0;
        end else begin
            tx_en <= step & (~quad | (cnt == '0));
            if (step & quad)
                cnt <= (cnt == CNT_W'(DIV - 1)) ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/octa_rx.sv
module octa_rx
    import octa_rx_pkg::*;
#(
    parameter int SLOT_W      = 32,
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TX_DIV      = 4,
    localparam int PAIRS  = NUM_CH / 2,
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int CH_W   = PAIR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              quad_en,
    input  logic              bclk_in,
    input  logic              ws_in,
    input  logic              mark_in,
    input  logic              sd_in,
    output logic [SLOT_W-1:0] smp_data,
    output logic [CH_W-1:0]   smp_chan,
    output logic              smp_valid,
    output logic              frame_err,
    output logic              tx_bclk_en
);
    rx_mode_e          mode;
    logic              quad;
    line_t             lines;
    logic              bclk_rise;
    logic [SLOT_W-1:0] word;
    logic              slot_keep;
    logic [CH_W-1:0]   slot_chan;
    logic              err;

    assign mode = rx_mode_e'(quad_en);
    assign quad = (mode == MODE_QUAD);

    octa_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .bclk_raw  (bclk_in),
        .ws_raw    (ws_in),
        .mk_raw    (mark_in),
        .sd_raw    (sd_in),
        .lines     (lines),
        .bclk_rise (bclk_rise)
    );

    octa_rx_shift #(.W(SLOT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bclk_rise),
        .sd       (lines.sd),
        .word     (word)
    );

    octa_rx_frame #(.PAIRS(PAIRS)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .quad      (quad),
        .step      (bclk_rise),
        .ln        (lines),
        .slot_keep (slot_keep),
        .slot_chan (slot_chan),
        .err       (err)
    );

    octa_rx_txdiv #(.DIV(TX_DIV)) u_txdiv (
        .clk   (clk),
        .rst   (rst),
        .quad  (quad),
        .step  (bclk_rise),
        .tx_en (tx_bclk_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_data  <= '0;
            smp_chan  <= '0;
            smp_valid <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            smp_valid <= slot_keep;
            frame_err <= err;
            if (slot_keep) begin
                smp_data <= word;
                smp_chan <= slot_chan;
            end
        end
    end

endmodule

// File: rtl/octa_rx_chk.sv
module octa_rx_chk #(
    parameter int TX_DIV = 4,
    parameter int CH_W   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            quad_en,
    input logic            bclk_rise,
    input logic            smp_valid,
    input logic [CH_W-1:0] smp_chan,
    input logic            frame_err,
    input logic            tx_bclk_en
);
    logic [7:0] rises;
    logic       seen_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rises   <= '0;
            seen_tx <= 1'b0;
        end else if (tx_bclk_en) begin
            rises   <= bclk_rise ? 8'd1 : 8'd0;
            seen_tx <= 1'b1;
        end else if (bclk_rise && rises != 8'hFF) begin
            rises <= rises + 8'd1;
        end
    end

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    p_valid_after_edge_r10: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(bclk_rise));

    p_stereo_chan_r2: assert property (@(posedge clk) disable iff (rst)
        (!quad_en && smp_valid) |-> (smp_chan < CH_W'(2)));

    p_stereo_no_err_r4: assert property (@(posedge clk) disable iff (rst)
        !quad_en |-> !frame_err);

    p_err_drops_slot_r7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !smp_valid);

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    p_tx_every_edge_r8: assert property (@(posedge clk) disable iff (rst)
        !quad_en |-> (tx_bclk_en == $past(bclk_rise)));

    p_tx_quarter_r9: assert property (@(posedge clk) disable iff (rst)
        (quad_en && tx_bclk_en && seen_tx) |-> (rises == 8'(TX_DIV)));

endmodule

bind octa_rx octa_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .quad_en    (quad_en),
    .bclk_rise  (bclk_rise),
    .smp_valid  (smp_valid),
    .smp_chan   (smp_chan),
    .frame_err  (frame_err),
    .tx_bclk_en (tx_bclk_en)
);

// File: tb/octa_rx_test.sv
`timescale 1ns/1ps
module octa_rx_test;
    localparam int MAXW = 64;
    localparam int MAXB = MAXW * 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        quad_en = 1'b0;
    logic        bclk_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        mark_in = 1'b0;
    logic        sd_in = 1'b0;
    logic [31:0] smp_data;
    logic [2:0]  smp_chan;
    logic        smp_valid;
    logic        frame_err;
    logic        tx_bclk_en;

    always #2 clk = ~clk;

    octa_rx uut (
        .clk        (clk),
        .rst        (rst),
        .quad_en    (quad_en),
        .bclk_in    (bclk_in),
        .ws_in      (ws_in),
        .mark_in    (mark_in),
        .sd_in      (sd_in),
        .smp_data   (smp_data),
        .smp_chan   (smp_chan),
        .smp_valid  (smp_valid),
        .frame_err  (frame_err),
        .tx_bclk_en (tx_bclk_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] words [0:MAXW-1];
    int          nwords;
    logic        ws_b [0:MAXB-1];
    logic        sd_b [0:MAXB-1];
    logic        mk_b [0:MAXB-1];
    int          nbits;

    logic [31:0] e_data [0:MAXW-1];
    int          e_ch   [0:MAXW-1];
    int          e_n, e_err;

    logic [31:0] g_data [0:MAXW-1];
    int          g_ch   [0:MAXW-1];
    int          g_n, g_err, g_tx;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (smp_valid) begin
                if (g_n < MAXW) begin
                    g_data[g_n] = smp_data;
                    g_ch[g_n]   = int'(smp_chan);
                end
                g_n++;
            end
            if (frame_err)  g_err++;
            if (tx_bclk_en) g_tx++;
        end
    end

    function automatic int chan_of(input bit quad, input int first, input int k);
        return quad ? (first + k) % 8 : (first + k) % 2;
    endfunction

    // Bit-level stream: one bit of lead for word select, marker high over pair 0.
    task automatic build(input bit quad, input int first, input bit rnd_mark);
        nbits = nwords * 32;
        for (int b = 0; b < nbits; b++) begin
            int w   = b / 32;
            int nxt = (b + 1) / 32;
            int cn;
            sd_b[b] = words[w][31 - (b % 32)];
            if (nxt < nwords) cn = chan_of(quad, first, nxt);
            else              cn = chan_of(quad, first, nwords - 1) ^ 1;
            ws_b[b] = cn[0];
            if (quad)          mk_b[b] = ((cn / 2) == 0) && (nxt < nwords);
            else if (rnd_mark) mk_b[b] = $urandom_range(0, 1) == 1;
            else               mk_b[b] = 1'b1;
        end
    endtask

    // Model of the requirements R2..R7.
    task automatic model(input bit quad);
        bit pws = 0, pmk = 0, primed = 0, locked = 0;
        int pair = 0;
        logic [31:0] sh = '0;
        e_n = 0; e_err = 0;
        for (int b = 0; b < nbits; b++) begin
            logic [31:0] wd = {sh[30:0], sd_b[b]};
            bit chg   = ws_b[b] != pws;
            bit npair = chg && pws && !ws_b[b];
            bit mrise = quad && mk_b[b] && !pmk;
            bit good  = mrise && npair;
            bit err   = mrise && !npair;
            if (chg && primed && (!quad || (locked && !err))) begin
                e_data[e_n] = wd;
                e_ch[e_n]   = quad ? pair * 2 + int'(pws) : int'(pws);
                e_n++;
            end
            if (err) e_err++;
            if (chg) primed = 1;
            if (err) locked = 0;
            else if (good) begin locked = 1; pair = 0; end
            else if (npair) pair = (pair + 1) % 4;
            sh = wd; pws = ws_b[b]; pmk = mk_b[b];
        end
    endtask

    task automatic do_reset(input bit quad);
        rst = 1'b1; bclk_in = 0; ws_in = 0; mark_in = 0; sd_in = 0;
        quad_en = quad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        g_n = 0; g_err = 0; g_tx = 0;
        @(negedge clk);
    endtask

    task automatic play();
        for (int b = 0; b < nbits; b++) begin
            bclk_in = 1'b0;
            ws_in = ws_b[b]; mark_in = mk_b[b]; sd_in = sd_b[b];
            repeat (4) @(negedge clk);
            bclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        bclk_in = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic compare(input bit quad, input string req);
        check(g_n == e_n, req, "slot count", g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            check(g_data[i] == e_data[i], req, $sformatf("data[%0d]", i), g_data[i], e_data[i]);
            check(g_ch[i] == e_ch[i], req, $sformatf("chan[%0d]", i), g_ch[i], e_ch[i]);
        end
        check(g_err == e_err, req, "frame_err count", g_err, e_err);
        if (quad) check(g_tx == (nbits + 3) / 4, "R9", "tx pulses", g_tx, (nbits + 3) / 4);
        else      check(g_tx == nbits, "R8", "tx pulses", g_tx, nbits);
    endtask

    initial begin
        void'($urandom(32'h5EED));

        // R1: reset state
        do_reset(1'b0);
        check(smp_valid == 0 && frame_err == 0 && tx_bclk_en == 0, "R1", "strobes after reset",
              {smp_valid, frame_err, tx_bclk_en}, 0);
        check(smp_data == 0 && smp_chan == 0, "R1", "data after reset", smp_data, 0);

        // R2/R3: stereo, directed corner words, marker held high
        nwords = 8;
        words[0] = 32'hDEAD_BEEF; words[1] = 32'h8000_0000; words[2] = 32'h0000_0001;
        words[3] = 32'hFFFF_FFFF; words[4] = 32'hABCD_0000; words[5] = 32'h0000_0000;
        words[6] = 32'h5A5A_A5A5; words[7] = 32'h1234_5678;
        build(1'b0, 0, 1'b0); model(1'b0);
        play();
        compare(1'b0, "R2");
        check(g_n == 7, "R3", "partial first slot dropped", g_n, 7);
        check(g_data[0] == 32'h8000_0000 && g_ch[0] == 1, "R3", "first slot out",
              g_data[0], 32'h8000_0000);

        // R4: stereo, random data, random marker activity
        do_reset(1'b0);
        nwords = 24;
        for (int i = 0; i < nwords; i++) words[i] = $urandom;
        build(1'b0, 0, 1'b1); model(1'b0);
        play();
        compare(1'b0, "R4");
        check(g_err == 0, "R4", "no framing error in stereo", g_err, 0);

        // R5: eight-slot, random data, marker every frame
        do_reset(1'b1);
        nwords = 34;
        for (int i = 0; i < nwords; i++) words[i] = $urandom;
        build(1'b1, 6, 1'b0); model(1'b1);
        play();
        compare(1'b1, "R5");
        check(g_n > 0 && g_ch[0] == 0, "R5", "first output is channel 0", g_ch[0], 0);

        // R6: eight-slot, marker only in the first frame
        do_reset(1'b1);
        nwords = 30;
        for (int i = 0; i < nwords; i++) words[i] = $urandom;
        build(1'b1, 6, 1'b0);
        for (int b = 32 * 10; b < nbits; b++) mk_b[b] = 1'b0;
        model(1'b1);
        play();
        compare(1'b1, "R6");
        check(g_n == nwords - 2, "R6", "flywheel keeps all slots", g_n, nwords - 2);

        // R7: misplaced marker mid-slot, and one on a low-to-high word-select change
        do_reset(1'b1);
        nwords = 30;
        for (int i = 0; i < nwords; i++) words[i] = $urandom;
        build(1'b1, 6, 1'b0);
        mk_b[32 * 5 + 10] = 1'b1;
        mk_b[32 * 13 - 1] = 1'b1;
        model(1'b1);
        play();
        compare(1'b1, "R7");
        check(g_err == 2, "R7", "two framing errors", g_err, 2);
        check(e_n < nwords - 2 && g_n == e_n, "R7", "slots dropped until realign", g_n, e_n);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule